// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller watches a parameterised set of asynchronous external lines, up to 32, that make up one bank. Each line passes through a two-stage synchronizer. A rising edge, a falling edge, or both can be chosen per line as a trigger. A detected trigger latches a per-line pending flag. A single combined interrupt output is raised while any pending line is also unmasked. A second, independent mask routes each detected edge to a per-line event output as a one-cycle pulse, for use as a wakeup signal.

Software reaches six 32-bit registers through a plain memory-mapped read/write port. Reads are combinational and writes take effect on the clock edge. Software clears pending flags by writing ones to them. It can also raise a pending flag itself through a software-trigger register. Bits that belong to lines beyond the implemented count always read as zero. Software can therefore write all ones to a trigger-select register and read the value back to learn how many lines exist.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and `event_o` is all zero.
- R2: The registers sit at these byte offsets: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bit n of each register belongs to line n. The mask and select registers read back what was written. Any other offset reads zero.
- R3: In every register, bits n at or above NUM_LINES read zero, even after a write of all ones.
- R4: When a line's rising select bit is 1, a 0-to-1 change on its input sets its pending bit on the third clock edge after the change. The first two edges are the synchronizer stages.
- R5: Falling detection is enabled by its own select bit. With both select bits set, either direction sets pending.
- R6: A line with neither select bit set never becomes pending from its input.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: If an enabled edge and a clear write reach the same line in the same cycle, the line stays pending.
- R9: Writing 1 to a software-trigger bit sets that pending bit and the trigger bit. The trigger bit reads 1 until its pending bit is cleared. Writing 0 to it has no effect.
- R10: `irq_o` is high exactly when some line has both its pending bit and its interrupt mask bit set.
- R11: When a line's event mask bit is 1, each enabled edge drives its `event_o` bit high for exactly one cycle. This happens in the cycle before pending sets, and does not depend on the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Asynchronous external lines |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt |
| event_o | output | NUM_LINES | Per-line event pulses |

## Verification
A bad synchronizer depth or a bad edge-compare register shows up as `event_o` pulsing one cycle early or late. It also shows `irq_o` rising out of step with the three-edge latency, within four cycles of the input change. A wrong pending or software-trigger state reaches the pending and trigger registers on the very next read. Wrong clear priority, where a clear beats an edge, leaves pending at zero right after the colliding write. Wrong width masking shows in the readback of an all-ones write.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned REG_BITS = 32;
  localparam int unsigned ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] OFS_IMASK  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EMASK  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RISE   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_FALL   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SWTRIG = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 5'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IMASK, SEL_EMASK, SEL_RISE, SEL_FALL, SEL_SWTRIG, SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
    case (a)
      OFS_IMASK:  return SEL_IMASK;
      OFS_EMASK:  return SEL_EMASK;
      OFS_RISE:   return SEL_RISE;
      OFS_FALL:   return SEL_FALL;
      OFS_SWTRIG: return SEL_SWTRIG;
      OFS_PEND:   return SEL_PEND;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/extint_line.sv
module extint_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic evt_en_i,
  input  logic sw_set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic swtrig_o,
  output logic event_o
);
  logic prev_q, pend_q, swtrig_q;
  logic hw_edge, pend_d, swtrig_d;

  assign hw_edge  = (rise_en_i & sync_i & ~prev_q) | (fall_en_i & ~sync_i & prev_q);
  // edge and software set both win over a same-cycle clear
  assign pend_d   = (pend_q & ~clr_i) | hw_edge | sw_set_i;
  assign swtrig_d = sw_set_i | (swtrig_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      pend_q   <= 1'b0;
      swtrig_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      pend_q   <= pend_d;
      swtrig_q <= swtrig_d;
    end
  end

  assign pend_o   = pend_q;
  assign swtrig_o = swtrig_q;
  assign event_o  = hw_edge & evt_en_i;

  AST_EDGE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_edge |=> pend_q); // R4
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_edge && clr_i) |=> pend_q); // R8
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hw_edge && !sw_set_i) |=> !pend_q && !swtrig_q); // R7
  AST_SW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i |=> pend_q && swtrig_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i && !sw_set_i && !pend_q) |=> !pend_q); // R6
  AST_EVT_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> pend_q); // R11
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 23,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  line_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_BITS-1:0]   wdata_i,
  output logic [REG_BITS-1:0]   rdata_o,
  output logic                  irq_o,
  output logic [NUM_LINES-1:0]  event_o
);
  localparam int unsigned N = NUM_LINES;

  reg_sel_e       sel;
  logic [N-1:0]   imask_q, emask_q, rise_q, fall_q;
  logic [N-1:0]   sync_q, pend_vec, swtrig_vec, clr_vec, set_vec;
  logic [N-1:0]   wbits;

  assign sel   = decode_addr(addr_i);
  assign wbits = wdata_i[N-1:0];

  extint_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_IMASK: imask_q <= wbits;
        SEL_EMASK: emask_q <= wbits;
        SEL_RISE:  rise_q  <= wbits;
        SEL_FALL:  fall_q  <= wbits;
        default: ;
      endcase
    end
  end

  assign clr_vec = (we_i && sel == SEL_PEND)   ? wbits : '0;
  assign set_vec = (we_i && sel == SEL_SWTRIG) ? wbits : '0;

  for (genvar n = 0; n < N; n++) begin : g_line
    extint_line u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (sync_q[n]),
      .rise_en_i(rise_q[n]),
      .fall_en_i(fall_q[n]),
      .evt_en_i (emask_q[n]),
      .sw_set_i (set_vec[n]),
      .clr_i    (clr_vec[n]),
      .pend_o   (pend_vec[n]),
      .swtrig_o (swtrig_vec[n]),
      .event_o  (event_o[n])
    );
  end

  always_comb begin
    case (sel)
      SEL_IMASK:  rdata_o = REG_BITS'(imask_q);
      SEL_EMASK:  rdata_o = REG_BITS'(emask_q);
      SEL_RISE:   rdata_o = REG_BITS'(rise_q);
      SEL_FALL:   rdata_o = REG_BITS'(fall_q);
      SEL_SWTRIG: rdata_o = REG_BITS'(swtrig_vec);
      SEL_PEND:   rdata_o = REG_BITS'(pend_vec);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend_vec & imask_q);

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_q == '0) |-> !irq_o); // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |-> (rdata_o == '0)); // R2
  AST_NO_EVT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((event_o & ~emask_q) == '0)); // R11
endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
  localparam int N = 23;
  localparam logic [31:0] ALL = 32'h007F_FFFF;

  logic clk = 0, rst_ni = 0, we = 0;
  logic [N-1:0] line = '0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [N-1:0] evt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  extint_ctrl u0 (.clk_i(clk), .rst_ni(rst_ni), .line_i(line), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .event_o(evt));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic rdchk(string tag, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 32; a += 4) rdchk("R1 reset reg", 5'(a), 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 event", 32'(evt), 0);
  endtask

  task automatic t_regs;
    wr(5'h00, 32'h0000_1234); rdchk("R2 imask", 5'h00, 32'h0000_1234);
    wr(5'h04, 32'h0000_0ab0); rdchk("R2 emask", 5'h04, 32'h0000_0ab0);
    wr(5'h0C, 32'h0000_5500); rdchk("R2 fall", 5'h0C, 32'h0000_5500);
    rdchk("R2 imask kept", 5'h00, 32'h0000_1234);
    wr(5'h18, 32'hffff_ffff); rdchk("R2 unused", 5'h18, 32'h0);
    rdchk("R2 unused 1c", 5'h1C, 32'h0);
    wr(5'h08, 32'hffff_ffff); rdchk("R3 rise width", 5'h08, ALL);
    wr(5'h00, 32'hffff_ffff); rdchk("R3 imask width", 5'h00, ALL);
    wr(5'h10, 32'hff80_0000); rdchk("R3 swtrig width", 5'h10, 32'h0);
    rdchk("R3 pend width", 5'h14, 32'h0);
    wr(5'h00, 0); wr(5'h04, 0); wr(5'h08, 0); wr(5'h0C, 0);
  endtask

  // edge on line n; event visible after 2 edges, pending after 3
  task automatic t_rise;
    wr(5'h08, 32'h1); wr(5'h04, 32'h1);
    @(negedge clk); line[0] = 1;
    wait_cyc(1); chk("R4 no event after 1 edge", 32'(evt[0]), 0);
    wait_cyc(1); chk("R11 event pulse", 32'(evt[0]), 1);
    rdchk("R4 not pending yet", 5'h14, 32'h0);
    wait_cyc(1); chk("R11 event one cycle", 32'(evt[0]), 0);
    rdchk("R4 pending set", 5'h14, 32'h1);
    chk("R10 masked irq low", 32'(irq), 0);
    wr(5'h00, 32'h1); chk("R10 irq high", 32'(irq), 1);
    wr(5'h14, 32'h0); rdchk("R7 write zero keeps", 5'h14, 32'h1);
    wr(5'h14, 32'h1); rdchk("R7 clear", 5'h14, 32'h0);
    chk("R10 irq low after clear", 32'(irq), 0);
    @(negedge clk); line[0] = 0; wait_cyc(4);
    rdchk("R5 fall ignored when only rise", 5'h14, 32'h0);
    wr(5'h00, 0); wr(5'h04, 0); wr(5'h08, 0);
  endtask

  task automatic t_fall_both;
    @(negedge clk); line[3] = 1; line[4] = 1; wait_cyc(4);
    rdchk("R6 no select no pending", 5'h14, 32'h0);
    wr(5'h0C, 32'h0000_0018); wr(5'h08, 32'h0000_0010);
    @(negedge clk); line[3] = 0; line[4] = 0; wait_cyc(4);
    rdchk("R5 fall on 3 and 4", 5'h14, 32'h18);
    wr(5'h14, 32'h18);
    @(negedge clk); line[3] = 1; line[4] = 1; wait_cyc(4);
    rdchk("R5 rise only on both-line 4", 5'h14, 32'h10);
    wr(5'h14, 32'h10); rdchk("R7 cleared", 5'h14, 32'h0);
  endtask

  task automatic t_collide;
    // line 4 has both edges enabled; make it pending first
    @(negedge clk); line[4] = 0; wait_cyc(4);
    rdchk("R8 setup pending", 5'h14, 32'h10);
    @(negedge clk); line[4] = 1;
    wait_cyc(1);
    @(negedge clk); we = 1; addr = 5'h14; wdata = 32'h10;
    chk("R11 no event when unmasked", 32'(evt[4]), 0);
    @(negedge clk); we = 0;
    rdchk("R8 edge wins over clear", 5'h14, 32'h10);
    wr(5'h14, 32'h10); rdchk("R8 later clear works", 5'h14, 32'h0);
    wr(5'h08, 0); wr(5'h0C, 0);
  endtask

  task automatic t_sw;
    wr(5'h10, 32'h20);
    rdchk("R9 pend from sw", 5'h14, 32'h20);
    rdchk("R9 swtrig reads 1", 5'h10, 32'h20);
    wr(5'h10, 32'h0); rdchk("R9 write 0 no effect", 5'h10, 32'h20);
    wr(5'h00, 32'h40); chk("R10 other mask irq low", 32'(irq), 0);
    wr(5'h00, 32'h60); chk("R10 irq high sw", 32'(irq), 1);
    wr(5'h14, 32'h20);
    rdchk("R9 swtrig cleared", 5'h10, 32'h0);
    rdchk("R9 pend cleared", 5'h14, 32'h0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    wait_cyc(3); rst_ni = 1; wait_cyc(1);
    t_reset; t_regs; t_rise; t_fall_both; t_collide; t_sw;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule